// File: doc/BRIEF.md
# Cascadable Presettable Decade Counter

This block is one counting digit for a decimal counter chain. It holds a 4-bit value that steps 0, 1, ..., 9 and then returns to 0 on rising clock edges. The digit can be forced to zero at any moment by an active-low clear that does not wait for the clock. It can also be preset from a 4-bit data bus through an active-low load, which takes effect at the next rising edge.

Counting needs two active-high enables together. The first, `advEn`, only lets the digit advance. The second, `chainEn`, also gates the terminal-count flag. The flag is high while the digit shows nine and `chainEn` is high. It is decoded without a register, so a stage can feed its flag straight into the `chainEn` of the next more significant stage and give a look-ahead carry.

The modulus and the digit width are parameters. The default values give a BCD decade.

Top module: `decade_stage`

## Requirements
- R1: While `clearN` is low, `count` is 0000 at once, with no clock edge needed, whatever `loadN`, `advEn`, `chainEn` and `dataIn` are doing.
- R2: When `loadN` is low at a rising edge and `clearN` is high, `count` takes the value of `dataIn`, whatever the levels of `advEn` and `chainEn`.
- R3: When `loadN`, `advEn` and `chainEn` are all high at a rising edge and `count` is below 9, `count` increases by exactly one.
- R4: The count is decimal. From 9, an enabled rising edge gives 0, so ten enabled edges return the counter to its starting value.
- R5: When `loadN` is high and either `advEn` or `chainEn` is low, `count` keeps its value across rising edges.
- R6: `termCount` is high exactly when `count` equals 9 and `chainEn` is high. It follows a change of `chainEn` in the same cycle, with no clock edge needed.
- R7: `advEn` has no effect on `termCount`. At count 9 with `chainEn` high, `termCount` stays high whether `advEn` is high or low.
- R8: When a value from 10 to 15 has been loaded, `termCount` stays low, and the next enabled rising edge sets `count` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes other than clear happen on its rising edge |
| clearN | input | 1 | Active-low asynchronous clear of the count |
| loadN | input | 1 | Active-low synchronous preset from `dataIn` |
| advEn | input | 1 | Count enable that only gates advancing |
| chainEn | input | 1 | Count enable that also gates `termCount`; driven by the previous stage's carry |
| dataIn | input | 4 | Preset value |
| count | output | 4 | Current digit value, bit 0 least significant |
| termCount | output | 1 | High while the count is 9 and `chainEn` is high |

## Verification
The bench builds the block with its default parameters: a 4-bit digit and a modulus of ten. These values put every code the bus can carry within reach. That covers the full 0 to 9 cycle with its wrap, and also the six codes from 10 to 15, which can only be reached by loading and which show how the stage recovers from them. The tests also drive clear between clock edges, and toggle `chainEn` between edges while the digit shows nine. This observes the two paths that need no clock: the clear and the terminal-count decode.

// File: rtl/decade_pkg.sv
package decade_pkg;

  // Strobes from the control to the datapath for one clock edge.
  typedef struct packed {
    logic doLoad;   // copy preset bus into the digit
    logic doStep;   // advance the digit by one (modulo)
  } stageCmd_t;

endpackage

// File: rtl/decade_datapath.sv
module decade_datapath
  import decade_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic             clk,
  input  logic             clearN,
  input  stageCmd_t        cmd,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             atLast
);

  localparam logic [WIDTH-1:0] LAST_VAL = WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] ONE_VAL  = WIDTH'(1);

  logic [WIDTH-1:0] digitQ;
  logic [WIDTH-1:0] stepVal;
  logic [WIDTH-1:0] nextVal;

  // A value at or past the last legal code wraps to zero.
  always_comb begin
    if (digitQ >= LAST_VAL) stepVal = '0;
    else                    stepVal = digitQ + ONE_VAL;
  end

  always_comb begin
    if (cmd.doLoad)      nextVal = dataIn;
    else if (cmd.doStep) nextVal = stepVal;
    else                 nextVal = digitQ;
  end

  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN) digitQ <= '0;
    else         digitQ <= nextVal;
  end

  assign count  = digitQ;
  assign atLast = (digitQ == LAST_VAL);

endmodule

// File: rtl/decade_control.sv
module decade_control
  import decade_pkg::*;
(
  input  logic      loadN,
  input  logic      advEn,
  input  logic      chainEn,
  input  logic      atLast,
  output stageCmd_t cmd,
  output logic      termCount
);

  // Load overrides both enables; stepping needs both enables.
  always_comb begin
    cmd.doLoad = !loadN;
    cmd.doStep = loadN && advEn && chainEn;
  end

  // Carry decode has no register, so a chain sees it in the same cycle.
  assign termCount = atLast && chainEn;

endmodule

// File: rtl/decade_stage.sv
module decade_stage
  import decade_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic             advEn,
  input  logic             chainEn,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             termCount
);

  stageCmd_t cmd;
  logic      atLast;

  decade_control uCtrl (
    .loadN     (loadN),
    .advEn     (advEn),
    .chainEn   (chainEn),
    .atLast    (atLast),
    .cmd       (cmd),
    .termCount (termCount)
  );

  decade_datapath #(
    .WIDTH   (WIDTH),
    .MODULUS (MODULUS)
  ) uData (
    .clk    (clk),
    .clearN (clearN),
    .cmd    (cmd),
    .dataIn (dataIn),
    .count  (count),
    .atLast (atLast)
  );

endmodule

// File: rtl/decade_stage_chk.sv
module decade_stage_chk #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input logic             clk,
  input logic             clearN,
  input logic             loadN,
  input logic             advEn,
  input logic             chainEn,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] count,
  input logic             termCount
);

  localparam logic [WIDTH-1:0] LAST_VAL = WIDTH'(MODULUS - 1);

  // R1
  a_r1_clear_zero: assert property (@(posedge clk) !clearN |-> (count == '0));

  // R2
  a_r2_load_copies: assert property (@(posedge clk) disable iff (!clearN)
    !loadN |=> (count == $past(dataIn)));

  // R3
  a_r3_step_one: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && advEn && chainEn && (count < LAST_VAL)) |=> (count == $past(count) + 1'b1));

  // R4
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && advEn && chainEn && (count == LAST_VAL)) |=> (count == '0));

  // R5
  a_r5_hold_value: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && !(advEn && chainEn)) |=> $stable(count));

  // R6
  a_r6_flag_needs_last: assert property (@(posedge clk) disable iff (!clearN)
    termCount |-> ((count == LAST_VAL) && chainEn));

  // R7
  a_r7_flag_ignores_adv: assert property (@(posedge clk) disable iff (!clearN)
    ((count == LAST_VAL) && chainEn) |-> termCount);

  // R8
  a_r8_no_flag_out_of_range: assert property (@(posedge clk) disable iff (!clearN)
    (count > LAST_VAL) |-> !termCount);

  a_r8_recover_zero: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && advEn && chainEn && (count > LAST_VAL)) |=> (count == '0));

endmodule

bind decade_stage decade_stage_chk #(
  .WIDTH   (WIDTH),
  .MODULUS (MODULUS)
) uChk (
  .clk       (clk),
  .clearN    (clearN),
  .loadN     (loadN),
  .advEn     (advEn),
  .chainEn   (chainEn),
  .dataIn    (dataIn),
  .count     (count),
  .termCount (termCount)
);

// File: tb/sim_decade_stage.sv
`timescale 1ns/1ps
module sim_decade_stage;

  logic       clk = 1'b0;
  logic       clearN = 1'b0;
  logic       loadN = 1'b1;
  logic       advEn = 1'b0;
  logic       chainEn = 1'b0;
  logic [3:0] dataIn = 4'd0;
  logic [3:0] count;
  logic       termCount;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  decade_stage u0 (
    .clk(clk), .clearN(clearN), .loadN(loadN), .advEn(advEn),
    .chainEn(chainEn), .dataIn(dataIn), .count(count), .termCount(termCount)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Advance one rising edge, then step 1 ns away from it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic tReset();
    clearN = 1'b0;
    tick();
    check("R1 reset count", count, 0);
    check("R6 reset flag", termCount, 0);
    clearN = 1'b1;
    tick();
  endtask

  task automatic tLoad();
    advEn = 1'b0; chainEn = 1'b0; loadN = 1'b0; dataIn = 4'd6;
    tick();
    check("R2 load enables low", count, 6);
    advEn = 1'b1; chainEn = 1'b1; dataIn = 4'd3;
    tick();
    check("R2 load overrides enables", count, 3);
    loadN = 1'b1; advEn = 1'b0; chainEn = 1'b0;
  endtask

  task automatic tSequence();
    loadN = 1'b0; dataIn = 4'd0;
    tick();
    loadN = 1'b1; advEn = 1'b1; chainEn = 1'b1;
    for (int i = 1; i <= 10; i++) begin
      tick();
      check("R3 R4 sequence", count, i % 10);
    end
    advEn = 1'b0; chainEn = 1'b0;
  endtask

  task automatic tHold();
    loadN = 1'b0; dataIn = 4'd4;
    tick();
    loadN = 1'b1; advEn = 1'b1; chainEn = 1'b0;
    tick(); tick();
    check("R5 hold chainEn low", count, 4);
    advEn = 1'b0; chainEn = 1'b1;
    tick(); tick();
    check("R5 hold advEn low", count, 4);
    chainEn = 1'b0;
  endtask

  task automatic tFlag();
    loadN = 1'b0; dataIn = 4'd8;
    tick();
    loadN = 1'b1; chainEn = 1'b1; advEn = 1'b0;
    #0.5;
    check("R6 flag low at 8", termCount, 0);
    advEn = 1'b1;
    tick();
    check("R3 reach 9", count, 9);
    check("R6 flag high at 9", termCount, 1);
    advEn = 1'b0;
    #0.5;
    check("R7 flag with advEn low", termCount, 1);
    chainEn = 1'b0;
    #0.5;
    check("R6 flag follows chainEn low", termCount, 0);
    chainEn = 1'b1;
    #0.5;
    check("R6 flag follows chainEn high", termCount, 1);
    advEn = 1'b1;
    tick();
    check("R4 wrap from 9", count, 0);
    check("R6 flag low after wrap", termCount, 0);
    advEn = 1'b0; chainEn = 1'b0;
  endtask

  task automatic tOutOfRange();
    for (int v = 10; v <= 15; v++) begin
      loadN = 1'b0; dataIn = 4'(v);
      advEn = 1'b0; chainEn = 1'b1;
      tick();
      check("R8 loaded value", count, v);
      check("R8 flag low out of range", termCount, 0);
      loadN = 1'b1; advEn = 1'b1;
      tick();
      check("R8 recover to zero", count, 0);
    end
    advEn = 1'b0; chainEn = 1'b0;
  endtask

  task automatic tClearMid();
    loadN = 1'b0; dataIn = 4'd9; chainEn = 1'b1;
    tick();
    loadN = 1'b1;
    check("R2 load 9", count, 9);
    clearN = 1'b0;
    #0.5;
    check("R1 clear between edges", count, 0);
    check("R6 flag cleared", termCount, 0);
    loadN = 1'b0; advEn = 1'b1; dataIn = 4'd5;
    tick();
    check("R1 clear beats load", count, 0);
    clearN = 1'b1; loadN = 1'b1; advEn = 1'b0; chainEn = 1'b0;
    tick();
  endtask

  initial begin
    tReset();
    tLoad();
    tSequence();
    tHold();
    tFlag();
    tOutOfRange();
    tClearMid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule